// File: doc/BRIEF.md
# Successive-Approximation Conversion Sequencer

This block is the digital control half of a 10-bit successive-approximation converter. Software drives it through a small write port with four addresses: a control byte, the two bytes of a 16-bit result pair and a completion flag. Once the converter is enabled, setting the start bit launches a conversion. The block then drives a trial code to an external DAC/comparator pair and reads back a single decision bit each period of the conversion clock (TAD). It resolves the code from the top bit down and stores it in the result pair, either left or right justified with zero padding.

TAD comes from a prescaler that divides the system clock by 2, 8 or 32. A start request waits for the next TAD tick. After that, one setup period and ten bit periods make up the conversion. At completion the block writes the result, clears the start/busy bit and raises a sticky flag, all on one edge. Clearing the start bit during a conversion aborts it and leaves the stored result untouched. The block then observes a recovery of exactly two TAD periods, after which tracking of the input resumes and a new start is accepted. While the converter is disabled, the two result bytes act as plain software registers.

A sample-hold output disconnects the holding capacitor for the duration of the bit-resolving phase. A tracking output shows when the input is being followed.

Top module: `sar_seq`

## Requirements
- R1: The control byte is at address 0. Bits [4:3] select the TAD divide: 0 gives 2 system cycles, 1 gives 8, and 2 or 3 give 32. The TAD counter restarts from zero whenever the converter is enabled and whenever a conversion is aborted.
- R2: With the converter already enabled (control bit 1) and the block idle, writing control bit 0 (start) as 1 sets go_o on that write edge. go_o then falls between 11N+1 and 12N cycles after the write edge, where N is the TAD divide.
- R3: Result bits are resolved from bit 9 down to bit 0, one per TAD. A comparator input of 1 keeps the trial bit. With a comparator that reports input >= trial code, the stored result equals the input code.
- R4: On the completion edge, the result pair is written, go_o clears and flag_o sets.
- R5: With control bit 2 (format) at 0, the result is left justified: res_hi_o holds result[9:2], res_lo_o[7:6] holds result[1:0], and res_lo_o[5:0] is zero.
- R6: With format at 1, the result is right justified: res_hi_o[1:0] holds result[9:8], res_lo_o holds result[7:0], and res_hi_o[7:2] is zero.
- R7: A control write with enable 1 and start 0 while go_o is high aborts the conversion. go_o and hold_o drop on that edge, and res_hi_o, res_lo_o and flag_o keep their previous values.
- R8: After an abort, track_o returns high exactly 2N cycles after the abort edge. Start writes made before then leave go_o low.
- R9: Writes to address 1 (high byte) and address 2 (low byte) load the result pair. While the converter is disabled these values are never overwritten. Clearing enable mid-conversion drops go_o without a result write.
- R10: A single control write that sets both enable and start while the converter was disabled enables it but does not start a conversion.
- R11: A start write while go_o is already high has no effect, and the running conversion completes at its original time with a correct result.
- R12: flag_o stays set until software writes address 3 with bit 0 at 0. When completion and a flag write fall on the same edge, completion wins.
- R13: hold_o rises at the TAD tick that starts conversion and falls at completion, abort or disable. track_o is high while the converter is enabled and either idle or waiting for that tick.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| wr_en_i | input | 1 | Register write strobe |
| wr_addr_i | input | 2 | Write address: 0 control, 1 high byte, 2 low byte, 3 flag |
| wr_data_i | input | 8 | Write data |
| cmp_i | input | 1 | Comparator decision, 1 when the input is at or above the trial code |
| go_o | output | 1 | Start/busy bit |
| res_hi_o | output | 8 | High byte of the result pair |
| res_lo_o | output | 8 | Low byte of the result pair |
| flag_o | output | 1 | Sticky completion flag |
| trial_o | output | 10 | Trial code driven to the DAC |
| hold_o | output | 1 | Sample-hold disconnect |
| track_o | output | 1 | Input tracking active |

## Verification
A control or data write takes effect on the edge that samples it, so go_o, hold_o and the result bytes are due at the falling edge right after that write. Completion falls between 11N+1 and 12N cycles after an accepted start, depending on the TAD phase. The bench counts falling edges from the start write until go_o drops and checks that the count lies in this window. After an abort, track_o must rise at exactly the 16th falling edge for a divide of 8. A behavioural model, stepped on each rising edge from the same inputs, is compared against every output at each falling edge, so every latency is held to the exact cycle.

// File: rtl/sar_seq_pkg.sv
// Shared definitions for the successive-approximation sequencer.
// Assumes: register fields decoded in the top module only.
package sar_seq_pkg;

    typedef enum logic [1:0] {
        ST_IDLE    = 2'd0,
        ST_SYNC    = 2'd1,
        ST_CONV    = 2'd2,
        ST_RECOVER = 2'd3
    } seq_state_t;

    // Write address map.
    localparam logic [1:0] ADDR_CTL  = 2'd0;
    localparam logic [1:0] ADDR_HI   = 2'd1;
    localparam logic [1:0] ADDR_LO   = 2'd2;
    localparam logic [1:0] ADDR_FLAG = 2'd3;

    // Control byte field positions.
    localparam int CTL_START_BIT = 0;
    localparam int CTL_EN_BIT    = 1;
    localparam int CTL_FMT_BIT   = 2;
    localparam int CTL_DIV_LSB   = 3;

endpackage

// File: rtl/sar_tad_prescaler.sv
// TAD tick generator: divides the system clock by 2^(1+2*sel),
// with sel clamped to SEL_MAX. Assumes run_i low holds the counter at zero.
module sar_tad_prescaler #(
    parameter int SEL_W   = 2,
    parameter int SEL_MAX = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             run_i,
    input  logic             clr_i,
    input  logic [SEL_W-1:0] sel_i,
    output logic             tick_o
);
    localparam int CNT_W = 1 + 2 * SEL_MAX;

    logic [CNT_W-1:0] cnt_q;
    logic [CNT_W-1:0] limit;
    int               sel_eff;

    // Terminal count for the selected divide.
    always_comb begin
        sel_eff = (int'(sel_i) > SEL_MAX) ? SEL_MAX : int'(sel_i);
        limit   = CNT_W'((1 << (1 + 2 * sel_eff)) - 1);
    end

    assign tick_o = run_i && (cnt_q >= limit);

    // Phase counter, restarted on clear, wrap or idle.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (!run_i || clr_i || tick_o) begin
            cnt_q <= '0;
        end else begin
            cnt_q <= cnt_q + 1'b1;
        end
    end

    // Divide is at least two, so ticks never come back to back.
    assert_tick_spacing_R1: assert property (@(posedge clk) disable iff (!rst_n)
        tick_o |=> !tick_o);

endmodule

// File: rtl/sar_approx_core.sv
// Conversion state machine and trial-code register.
// One setup TAD, then one bit per TAD from the top bit down; a fixed
// recovery of REC_TADS ticks follows an abort.
// Assumes: dis_i, abort_i and start_i come from one decoded write.
module sar_approx_core
    import sar_seq_pkg::*;
#(
    parameter int RES_W    = 10,
    parameter int REC_TADS = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             en_i,
    input  logic             dis_i,
    input  logic             abort_i,
    input  logic             start_i,
    input  logic             tick_i,
    input  logic             cmp_i,
    output logic             go_o,
    output logic             idle_o,
    output logic             hold_o,
    output logic             track_o,
    output logic             done_o,
    output logic [RES_W-1:0] trial_o,
    output logic [RES_W-1:0] result_o
);
    localparam int                STEP_W    = $clog2(RES_W + 1);
    localparam int                REC_W     = $clog2(REC_TADS + 1);
    localparam logic [STEP_W-1:0] LAST_STEP = STEP_W'(RES_W);
    localparam logic [REC_W-1:0]  LAST_REC  = REC_W'(REC_TADS - 1);

    seq_state_t        state_q;
    logic [STEP_W-1:0] step_q;
    logic [REC_W-1:0]  rec_q;
    logic [RES_W-1:0]  code_q;
    logic [RES_W-1:0]  code_n;
    logic              go_q;
    logic              hold_q;

    // Next trial code: settle the bit under test, raise the one below.
    always_comb begin
        code_n = code_q;
        for (int i = 0; i < RES_W; i++) begin
            if (int'(step_q) + i == RES_W)     code_n[i] = cmp_i;
            if (int'(step_q) + i == RES_W - 1) code_n[i] = 1'b1;
        end
    end

    assign done_o   = (state_q == ST_CONV) && tick_i && (step_q == LAST_STEP)
                      && !dis_i && !abort_i;
    assign result_o = code_n;
    assign trial_o  = code_q;
    assign go_o     = go_q;
    assign hold_o   = hold_q;
    assign idle_o   = (state_q == ST_IDLE);
    assign track_o  = en_i && ((state_q == ST_IDLE) || (state_q == ST_SYNC));

    // Sequencing: disable, then abort, then start, then TAD-paced steps.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
            step_q  <= '0;
            rec_q   <= '0;
            code_q  <= '0;
            go_q    <= 1'b0;
            hold_q  <= 1'b0;
        end else if (dis_i) begin
            state_q <= ST_IDLE;
            go_q    <= 1'b0;
            hold_q  <= 1'b0;
        end else if (abort_i) begin
            state_q <= ST_RECOVER;
            rec_q   <= '0;
            go_q    <= 1'b0;
            hold_q  <= 1'b0;
        end else if (start_i) begin
            state_q <= ST_SYNC;
            go_q    <= 1'b1;
        end else if (tick_i) begin
            case (state_q)
                ST_SYNC: begin
                    state_q <= ST_CONV;
                    step_q  <= '0;
                    code_q  <= '0;
                    hold_q  <= 1'b1;
                end
                ST_CONV: begin
                    code_q <= code_n;
                    step_q <= step_q + 1'b1;
                    if (step_q == LAST_STEP) begin
                        state_q <= ST_IDLE;
                        go_q    <= 1'b0;
                        hold_q  <= 1'b0;
                    end
                end
                ST_RECOVER: begin
                    rec_q <= rec_q + 1'b1;
                    if (rec_q == LAST_REC) state_q <= ST_IDLE;
                end
                default: ;
            endcase
        end
    end

    assert_hold_in_conv_R13: assert property (@(posedge clk) disable iff (!rst_n)
        hold_q |-> (state_q == ST_CONV));

    assert_recover_no_start_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_RECOVER) |=> (state_q != ST_SYNC));

    assert_abort_to_recover_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (abort_i && !dis_i) |=> (state_q == ST_RECOVER) && !go_q);

    assert_go_clears_at_done_R4: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |=> !go_q && !hold_q);

endmodule

// File: rtl/sar_result_regs.sv
// Result pair and completion flag. Packs a finished code left or right
// justified with zero padding; software may load either byte or the flag.
// Assumes BYTE_W < RES_W < 2*BYTE_W; completion beats a same-edge write.
module sar_result_regs #(
    parameter int RES_W  = 10,
    parameter int BYTE_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              commit_i,
    input  logic [RES_W-1:0]  value_i,
    input  logic              fmt_i,
    input  logic              hi_we_i,
    input  logic              lo_we_i,
    input  logic              flag_we_i,
    input  logic [BYTE_W-1:0] wdata_i,
    output logic [BYTE_W-1:0] hi_o,
    output logic [BYTE_W-1:0] lo_o,
    output logic              flag_o
);
    localparam int PAIR_W = 2 * BYTE_W;
    localparam int PAD_W  = PAIR_W - RES_W;

    logic [PAIR_W-1:0] packed_v;

    // Justification: format 1 right aligned, format 0 left aligned.
    always_comb begin
        if (fmt_i) packed_v = {{PAD_W{1'b0}}, value_i};
        else       packed_v = {value_i, {PAD_W{1'b0}}};
    end

    // High byte register.
    always_ff @(posedge clk) begin
        if (!rst_n)        hi_o <= '0;
        else if (commit_i) hi_o <= packed_v[PAIR_W-1:BYTE_W];
        else if (hi_we_i)  hi_o <= wdata_i;
    end

    // Low byte register.
    always_ff @(posedge clk) begin
        if (!rst_n)        lo_o <= '0;
        else if (commit_i) lo_o <= packed_v[BYTE_W-1:0];
        else if (lo_we_i)  lo_o <= wdata_i;
    end

    // Sticky completion flag.
    always_ff @(posedge clk) begin
        if (!rst_n)         flag_o <= 1'b0;
        else if (commit_i)  flag_o <= 1'b1;
        else if (flag_we_i) flag_o <= wdata_i[0];
    end

    assert_done_sets_flag_R4: assert property (@(posedge clk) disable iff (!rst_n)
        commit_i |=> flag_o);

    assert_left_pad_zero_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (commit_i && !fmt_i) |=> (lo_o[PAD_W-1:0] == '0));

    assert_right_pad_zero_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (commit_i && fmt_i) |=> (hi_o[BYTE_W-1:RES_W-BYTE_W] == '0));

endmodule

// File: rtl/sar_seq.sv
// Top of the conversion sequencer: decodes the write port into the
// control register and command pulses, and ties prescaler, core and
// result registers together. Assumes one write per cycle.
module sar_seq
    import sar_seq_pkg::*;
#(
    parameter int RES_W     = 10,
    parameter int BYTE_W    = 8,
    parameter int DIV_SEL_W = 2,
    parameter int DIV_MAX   = 2,
    parameter int REC_TADS  = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en_i,
    input  logic [1:0]        wr_addr_i,
    input  logic [BYTE_W-1:0] wr_data_i,
    input  logic              cmp_i,
    output logic              go_o,
    output logic [BYTE_W-1:0] res_hi_o,
    output logic [BYTE_W-1:0] res_lo_o,
    output logic              flag_o,
    output logic [RES_W-1:0]  trial_o,
    output logic              hold_o,
    output logic              track_o
);
    logic                 en_q;
    logic                 fmt_q;
    logic [DIV_SEL_W-1:0] sel_q;
    logic                 ctl_wr;
    logic                 dis_cmd;
    logic                 abort_cmd;
    logic                 start_cmd;
    logic                 tick;
    logic                 idle;
    logic                 done;
    logic [RES_W-1:0]     result;

    // Command decode from a control write.
    always_comb begin
        ctl_wr    = wr_en_i && (wr_addr_i == ADDR_CTL);
        dis_cmd   = ctl_wr && !wr_data_i[CTL_EN_BIT];
        abort_cmd = ctl_wr && wr_data_i[CTL_EN_BIT] && !wr_data_i[CTL_START_BIT] && go_o;
        start_cmd = ctl_wr && wr_data_i[CTL_EN_BIT] && wr_data_i[CTL_START_BIT]
                    && en_q && idle;
    end

    // Control fields held between writes.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            en_q  <= 1'b0;
            fmt_q <= 1'b0;
            sel_q <= '0;
        end else if (ctl_wr) begin
            en_q  <= wr_data_i[CTL_EN_BIT];
            fmt_q <= wr_data_i[CTL_FMT_BIT];
            sel_q <= wr_data_i[CTL_DIV_LSB +: DIV_SEL_W];
        end
    end

    sar_tad_prescaler #(
        .SEL_W  (DIV_SEL_W),
        .SEL_MAX(DIV_MAX)
    ) u_pre (
        .clk   (clk),
        .rst_n (rst_n),
        .run_i (en_q),
        .clr_i (abort_cmd),
        .sel_i (sel_q),
        .tick_o(tick)
    );

    sar_approx_core #(
        .RES_W   (RES_W),
        .REC_TADS(REC_TADS)
    ) u_core (
        .clk     (clk),
        .rst_n   (rst_n),
        .en_i    (en_q),
        .dis_i   (dis_cmd),
        .abort_i (abort_cmd),
        .start_i (start_cmd),
        .tick_i  (tick),
        .cmp_i   (cmp_i),
        .go_o    (go_o),
        .idle_o  (idle),
        .hold_o  (hold_o),
        .track_o (track_o),
        .done_o  (done),
        .trial_o (trial_o),
        .result_o(result)
    );

    sar_result_regs #(
        .RES_W (RES_W),
        .BYTE_W(BYTE_W)
    ) u_res (
        .clk      (clk),
        .rst_n    (rst_n),
        .commit_i (done),
        .value_i  (result),
        .fmt_i    (fmt_q),
        .hi_we_i  (wr_en_i && (wr_addr_i == ADDR_HI)),
        .lo_we_i  (wr_en_i && (wr_addr_i == ADDR_LO)),
        .flag_we_i(wr_en_i && (wr_addr_i == ADDR_FLAG)),
        .wdata_i  (wr_data_i),
        .hi_o     (res_hi_o),
        .lo_o     (res_lo_o),
        .flag_o   (flag_o)
    );

    assert_abort_keeps_result_R7: assert property (@(posedge clk) disable iff (!rst_n)
        abort_cmd |=> $stable(res_hi_o) && $stable(res_lo_o) && $stable(flag_o));

    assert_enable_write_no_start_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (ctl_wr && !en_q) |=> !go_o);

    assert_disabled_holds_result_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (!en_q && !wr_en_i) |=> $stable(res_hi_o) && $stable(res_lo_o));

endmodule

// File: tb/sar_seq_test.sv
`timescale 1ns/1ps
module sar_seq_test;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       wr_en = 1'b0;
    logic [1:0] wr_addr = '0;
    logic [7:0] wr_data = '0;
    logic [9:0] vin = '0;
    logic       cmp;
    logic       go, flag, hold, track;
    logic [7:0] hi, lo;
    logic [9:0] trial;

    int  nchk = 0;
    int  nfail = 0;
    bit  mdl_on = 1'b0;
    bit  finished = 1'b0;

    always #2 clk = ~clk;

    assign cmp = (vin >= trial);

    sar_seq uut (
        .clk(clk), .rst_n(rst_n), .wr_en_i(wr_en), .wr_addr_i(wr_addr),
        .wr_data_i(wr_data), .cmp_i(cmp), .go_o(go), .res_hi_o(hi),
        .res_lo_o(lo), .flag_o(flag), .trial_o(trial), .hold_o(hold),
        .track_o(track)
    );

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        nchk++;
        if (!ok) begin
            nfail++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    function automatic logic [7:0] ctlb(input bit en, input bit fmt, input int sel, input bit st);
        return 8'((sel << 3) | (int'(fmt) << 2) | (int'(en) << 1) | int'(st));
    endfunction

    // ---------------- behavioural reference model ----------------
    bit         m_en, m_fmt, m_go, m_hold, m_flag;
    int         m_sel, m_st, m_pc, m_k, m_rc;
    logic [9:0] m_code;
    logic [7:0] m_hi, m_lo;

    always @(posedge clk) begin
        int  div, b, pair;
        bit  tick, ctl, dis, abrt, strt, done, c;
        if (!rst_n) begin
            m_en = 0; m_fmt = 0; m_go = 0; m_hold = 0; m_flag = 0;
            m_sel = 0; m_st = 0; m_pc = 0; m_k = 0; m_rc = 0;
            m_code = '0; m_hi = '0; m_lo = '0;
        end else begin
            div  = (m_sel == 0) ? 2 : ((m_sel == 1) ? 8 : 32);
            tick = m_en && (m_pc >= div - 1);
            ctl  = wr_en && (wr_addr == 2'd0);
            dis  = ctl && !wr_data[1];
            abrt = ctl && wr_data[1] && !wr_data[0] && m_go;
            strt = ctl && wr_data[1] && wr_data[0] && m_en && (m_st == 0);
            done = 0;
            if (!m_en || abrt || tick) m_pc = 0; else m_pc++;
            if (dis) begin
                m_st = 0; m_go = 0; m_hold = 0;
            end else if (abrt) begin
                m_st = 3; m_rc = 0; m_go = 0; m_hold = 0;
            end else if (strt) begin
                m_st = 1; m_go = 1;
            end else if (tick) begin
                if (m_st == 1) begin
                    m_st = 2; m_k = 0; m_code = '0; m_hold = 1;
                end else if (m_st == 2) begin
                    if (m_k == 0) m_code = 10'h200;
                    else begin
                        b = 10 - m_k;
                        c = (vin >= m_code);
                        m_code[b] = c;
                        if (b > 0) m_code[b-1] = 1'b1;
                    end
                    if (m_k == 10) done = 1;
                    m_k++;
                end else if (m_st == 3) begin
                    m_rc++;
                    if (m_rc == 2) m_st = 0;
                end
            end
            if (done) begin
                pair = m_fmt ? int'(m_code) : (int'(m_code) << 6);
                m_hi = 8'(pair >> 8); m_lo = 8'(pair);
                m_flag = 1; m_go = 0; m_st = 0; m_hold = 0;
            end else if (wr_en) begin
                if (wr_addr == 2'd1) m_hi = wr_data;
                if (wr_addr == 2'd2) m_lo = wr_data;
                if (wr_addr == 2'd3) m_flag = wr_data[0];
            end
            if (ctl) begin
                m_en = wr_data[1]; m_fmt = wr_data[2]; m_sel = int'(wr_data[4:3]);
            end
        end
    end

    // Every-cycle comparison against the model.
    always @(negedge clk) begin
        if (rst_n && mdl_on && !finished) begin
            chk(go === m_go,       "R2 go_o vs model",    go,    m_go);
            chk(hi === m_hi,       "R5 res_hi_o vs model", hi,   m_hi);
            chk(lo === m_lo,       "R6 res_lo_o vs model", lo,   m_lo);
            chk(flag === m_flag,   "R12 flag_o vs model", flag,  m_flag);
            chk(hold === m_hold,   "R13 hold_o vs model", hold,  m_hold);
            chk(track === (m_en && (m_st <= 1)), "R8 track_o vs model", track,
                int'(m_en && (m_st <= 1)));
        end
    end

    // ---------------- stimulus ----------------
    task automatic wr(input logic [1:0] a, input logic [7:0] d);
        @(negedge clk);
        wr_en = 1'b1; wr_addr = a; wr_data = d;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic run_conv(input logic [9:0] v, input int sel, input bit fmt,
                            input int exp_hi, input int exp_lo);
        int n;
        int div;
        div = (sel == 0) ? 2 : ((sel == 1) ? 8 : 32);
        vin = v;
        wr(2'd0, ctlb(1, fmt, sel, 0));
        wr(2'd3, 8'h00);
        wr(2'd0, ctlb(1, fmt, sel, 1));
        chk(go == 1'b1, "R2 start sets go", go, 1);
        n = 0;
        while (go && n < 2000) begin
            @(negedge clk);
            n++;
        end
        chk(n >= 11*div + 1 && n <= 12*div, "R1/R2 conversion latency", n, 11*div + 1);
        chk(hi == 8'(exp_hi), "R3 high byte", hi, exp_hi);
        chk(lo == 8'(exp_lo), "R3 low byte", lo, exp_lo);
        chk(flag == 1'b1, "R4 flag at completion", flag, 1);
    endtask

    initial begin
        int n;
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        mdl_on = 1'b1;
        @(negedge clk);
        chk(go == 0 && hi == 0 && lo == 0 && flag == 0 && hold == 0 && track == 0,
            "R2 reset state", {go, flag, hold, track}, 0);

        // R9: result bytes as plain registers while disabled
        wr(2'd1, 8'h5A);
        wr(2'd2, 8'hC3);
        repeat (10) @(negedge clk);
        chk(hi == 8'h5A, "R9 high byte write", hi, 8'h5A);
        chk(lo == 8'hC3, "R9 low byte write", lo, 8'hC3);

        // R10: enable and start in one write
        wr(2'd0, ctlb(1, 0, 0, 1));
        chk(go == 0, "R10 start with enable ignored", go, 0);
        repeat (40) @(negedge clk);
        chk(go == 0 && hi == 8'h5A, "R10 no conversion after", go, 0);

        // R5: left justified, divide 2
        run_conv(10'h2B5, 0, 0, 8'hAD, 8'h40);
        // R12: flag sticky, then cleared
        repeat (20) @(negedge clk);
        chk(flag == 1, "R12 flag stays set", flag, 1);
        wr(2'd3, 8'h00);
        chk(flag == 0, "R12 flag cleared by write", flag, 0);

        // R6: right justified, divide 8
        run_conv(10'h1C6, 1, 1, 8'h01, 8'hC6);
        // R1: divide select 3 behaves as 32; extremes of code
        run_conv(10'h3FF, 3, 1, 8'h03, 8'hFF);
        run_conv(10'h000, 2, 0, 8'h00, 8'h00);

        // R11: start again while busy
        vin = 10'h0F0;
        wr(2'd0, ctlb(1, 1, 0, 0));
        wr(2'd0, ctlb(1, 1, 0, 1));
        n = 0;
        while (go && n < 2000) begin
            @(negedge clk);
            n++;
            if (n == 4) begin wr_en = 1'b1; wr_addr = 2'd0; wr_data = ctlb(1, 1, 0, 1); end
            else wr_en = 1'b0;
        end
        chk(n >= 23 && n <= 24, "R11 busy start keeps timing", n, 23);
        chk(hi == 8'h00 && lo == 8'hF0, "R11 busy start keeps result", lo, 8'hF0);

        // R7/R8/R13: abort keeps the result, exact recovery
        wr(2'd1, 8'h12);
        wr(2'd2, 8'h34);
        wr(2'd3, 8'h00);
        vin = 10'h155;
        wr(2'd0, ctlb(1, 0, 1, 0));
        wr(2'd0, ctlb(1, 0, 1, 1));
        repeat (30) @(negedge clk);
        chk(hold == 1, "R13 hold during conversion", hold, 1);
        wr(2'd0, ctlb(1, 0, 1, 0));
        chk(go == 0 && hold == 0 && track == 0, "R7 abort drops go and hold",
            {go, hold, track}, 0);
        chk(hi == 8'h12 && lo == 8'h34, "R7 abort keeps result", {hi, lo}, 16'h1234);
        chk(flag == 0, "R7 abort sets no flag", flag, 0);
        n = 0;
        while (!track && n < 200) begin
            @(negedge clk);
            n++;
            if (n == 2) begin wr_en = 1'b1; wr_addr = 2'd0; wr_data = ctlb(1, 0, 1, 1); end
            else wr_en = 1'b0;
            if (n == 3) chk(go == 0, "R8 start during recovery ignored", go, 0);
        end
        chk(n == 16, "R8 recovery lasts two TAD", n, 16);
        run_conv(10'h155, 1, 0, 8'h55, 8'h40);

        // R9: disable mid-conversion, then plain register use
        wr(2'd0, ctlb(1, 0, 0, 1));
        repeat (8) @(negedge clk);
        wr(2'd0, ctlb(0, 0, 0, 0));
        chk(go == 0 && hi == 8'h55 && lo == 8'h40, "R9 disable mid-conversion", go, 0);
        wr(2'd1, 8'hA5);
        wr(2'd2, 8'h0F);
        repeat (50) @(negedge clk);
        chk(hi == 8'hA5 && lo == 8'h0F, "R9 disabled bytes persist", {hi, lo}, 16'hA50F);

        repeat (4) @(negedge clk);
        finished = 1'b1;
        $display("%0d/%0d checks passed", nchk - nfail, nchk);
        $finish;
    end

    // Watchdog
    initial begin
        repeat (100000) @(posedge clk);
        if (!finished) begin
            finished = 1'b1;
            nchk++;
            nfail++;
            $display("FAIL watchdog R2 actual=%0d expected=%0d", 100000, 0);
            $display("%0d/%0d checks passed", nchk - nfail, nchk);
            $finish;
        end
    end
endmodule